// File: doc/BRIEF.md
# Timed Escape-Sequence Detector

This block watches the stream of bytes leaving a serial receiver and recognises a modem-style escape: a run of identical command characters that arrives after a period of silence, with only short pauses between its characters, and that is followed by another period of silence. Time is measured in baud-tick units. A free-running idle timer counts ticks since the last received byte. A small sequencer compares every byte and the idle time at its arrival against the programmed guards.

The receiver presents each byte with a one-cycle valid strobe. A shared timebase supplies one-cycle tick pulses. The configuration inputs set five values: the command character, how many of them are required, the quiet time before the first character, the longest pause allowed between characters, and the quiet time required after the last character. When the whole pattern is seen, the block emits a one-cycle detection pulse. It also reports whether a candidate sequence is in progress and how many characters of it have been matched.

Top module: `at_esc_detect`

## Requirements
- R1: After a synchronous active-low reset, esc_det, esc_busy and esc_matched are all 0, and the idle timer restarts from 0.
- R2: A command character starts a sequence only if at least cfg_pre_idle ticks have passed since the previous byte, or since reset. A character arriving earlier leaves esc_busy at 0.
- R3: While a sequence is being collected, any byte that differs from cfg_char abandons it. esc_busy and esc_matched return to 0 on the cycle after that byte.
- R4: If more than cfg_gap ticks pass without a byte while characters are being collected, the sequence is abandoned. A pause of exactly cfg_gap ticks is still accepted.
- R5: Once cfg_num characters have matched, esc_det stays 0 until cfg_post_idle ticks have passed with no byte. It then pulses exactly once, and esc_busy and esc_matched return to 0.
- R6: A byte of any value that arrives during the post-idle wait cancels the detection. No pulse is produced for that sequence.
- R7: A cfg_num of 0 behaves like 1, so a single well-guarded command character is a complete sequence.
- R8: esc_matched holds the number of characters accepted so far in the current sequence. It never exceeds the effective count. esc_busy is 1 from the first accepted character until the sequence is detected or abandoned.
- R9: esc_det is high for exactly one clock cycle per detection. It rises on the cycle after the first cycle with no byte in which the idle time has reached cfg_post_idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per baud period |
| rx_vld | input | 1 | Received byte valid, one cycle per byte |
| rx_data | input | 8 | Received byte |
| cfg_char | input | 8 | Command character to match |
| cfg_num | input | 8 | Number of command characters required (0 treated as 1) |
| cfg_pre_idle | input | 16 | Minimum idle ticks before the first character |
| cfg_gap | input | 16 | Maximum idle ticks between characters |
| cfg_post_idle | input | 16 | Idle ticks required after the last character |
| esc_det | output | 1 | One-cycle detection pulse |
| esc_busy | output | 1 | A candidate sequence is in progress |
| esc_matched | output | 8 | Characters matched in the current sequence |

## Verification
A byte's effect on esc_busy and esc_matched is visible one cycle after its valid cycle. A gap timeout shows up one cycle after the first byte-free cycle in which the idle count exceeds cfg_gap. A detection pulse appears one cycle after the first byte-free cycle in which the idle count has reached cfg_post_idle. The bench drives inputs on falling edges, so every tick is followed by a byte-free cycle. It adds settle cycles before it samples, so each check reads the outputs only after the register stage that produces the result has updated. Detection pulses are counted by a falling-edge monitor and compared with a tick-level model of the guards. That comparison covers both "exactly one" and "none" outcomes, and also catches a pulse that arrives too early.

// File: rtl/at_esc_pkg.sv
// Shared types for the timed escape-sequence detector.
package at_esc_pkg;
    typedef enum logic [1:0] {
        ESC_HUNT    = 2'd0,
        ESC_COLLECT = 2'd1,
        ESC_POST    = 2'd2
    } esc_state_e;
endpackage

// File: rtl/esc_idle_timer.sv
// Idle timer: counts baud ticks since the most recent received byte.
// Assumes baud_tick and byte_vld are single-cycle pulses in the clk domain.
// Saturates at the all-ones value so long silences never wrap to zero.
module esc_idle_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          byte_vld,
    output logic [TW-1:0] idle_cnt
);
    localparam logic [TW-1:0] IDLE_MAX = {TW{1'b1}};

    // Clear on every byte, otherwise count ticks up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (byte_vld)
            idle_cnt <= '0;
        else if (baud_tick && idle_cnt != IDLE_MAX)
            idle_cnt <= idle_cnt + 1'b1;
    end

    // R2
    idle_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> idle_cnt >= $past(idle_cnt));

    // R2
    idle_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> idle_cnt == '0);
endmodule

// File: rtl/esc_seq_ctrl.sv
// Sequencer: hunts for a guarded first character, collects the run of
// identical characters under the gap limit, then waits out the post-idle
// guard before pulsing det_pulse. Assumes idle_cnt is the tick count since
// the last byte, as seen in the same cycle as byte_vld.
module esc_seq_ctrl
    import at_esc_pkg::*;
#(
    parameter int CW = 8,
    parameter int NW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [CW-1:0] byte_data,
    input  logic [TW-1:0] idle_cnt,
    input  logic [CW-1:0] cfg_char,
    input  logic [NW-1:0] cfg_num,
    input  logic [TW-1:0] cfg_pre,
    input  logic [TW-1:0] cfg_gap,
    input  logic [TW-1:0] cfg_post,
    output logic          det_pulse,
    output logic          seq_busy,
    output logic [NW-1:0] seq_cnt
);
    localparam logic [NW-1:0] ONE = NW'(1);

    esc_state_e    st_q, st_d;
    logic [NW-1:0] cnt_q, cnt_d;
    logic          det_d;
    logic [NW-1:0] eff_num;
    logic          is_char, gap_expired, pre_ok, post_done, hunting;

    // Guard comparisons and the effective required count.
    always_comb begin
        eff_num     = (cfg_num == '0) ? ONE : cfg_num;
        is_char     = (byte_data == cfg_char);
        gap_expired = (idle_cnt > cfg_gap);
        pre_ok      = (idle_cnt >= cfg_pre);
        post_done   = (idle_cnt >= cfg_post);
        hunting     = (st_q == ESC_HUNT) || (st_q == ESC_COLLECT && gap_expired);
    end

    // Next-state decision for the sequence search.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        det_d = 1'b0;
        if (st_q == ESC_POST) begin
            if (byte_vld) begin
                st_d  = ESC_HUNT;
                cnt_d = '0;
            end else if (post_done) begin
                det_d = 1'b1;
                st_d  = ESC_HUNT;
                cnt_d = '0;
            end
        end else if (hunting) begin
            if (byte_vld && is_char && pre_ok) begin
                cnt_d = ONE;
                st_d  = (eff_num == ONE) ? ESC_POST : ESC_COLLECT;
            end else begin
                cnt_d = '0;
                st_d  = ESC_HUNT;
            end
        end else if (byte_vld) begin
            if (is_char) begin
                cnt_d = cnt_q + ONE;
                if (cnt_q + ONE >= eff_num)
                    st_d = ESC_POST;
            end else begin
                cnt_d = '0;
                st_d  = ESC_HUNT;
            end
        end
    end

    // State, count and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ESC_HUNT;
            cnt_q     <= '0;
            det_pulse <= 1'b0;
        end else begin
            st_q      <= st_d;
            cnt_q     <= cnt_d;
            det_pulse <= det_d;
        end
    end

    assign seq_busy = (st_q != ESC_HUNT);
    assign seq_cnt  = cnt_q;

    // R9
    det_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);

    // R5
    det_after_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> $past(st_q == ESC_POST) && !$past(byte_vld));

    // R6
    post_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ESC_POST && byte_vld) |=> (!det_pulse && st_q == ESC_HUNT));

    // R3
    mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ESC_COLLECT && byte_vld && !is_char) |=> (cnt_q == '0 && !seq_busy));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= eff_num);

    // R8
    busy_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> cnt_q != '0);
endmodule

// File: rtl/at_esc_detect.sv
// Top of the timed escape-sequence detector. Joins the idle timer to the
// sequencer. Assumes all inputs are synchronous to clk and that the
// configuration is held stable while a sequence is in progress.
module at_esc_detect #(
    parameter int CW = 8,
    parameter int NW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          rx_vld,
    input  logic [CW-1:0] rx_data,
    input  logic [CW-1:0] cfg_char,
    input  logic [NW-1:0] cfg_num,
    input  logic [TW-1:0] cfg_pre_idle,
    input  logic [TW-1:0] cfg_gap,
    input  logic [TW-1:0] cfg_post_idle,
    output logic          esc_det,
    output logic          esc_busy,
    output logic [NW-1:0] esc_matched
);
    logic [TW-1:0] idle_cnt;

    esc_idle_timer #(.TW(TW)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .byte_vld  (rx_vld),
        .idle_cnt  (idle_cnt)
    );

    esc_seq_ctrl #(.CW(CW), .NW(NW), .TW(TW)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (rx_vld),
        .byte_data (rx_data),
        .idle_cnt  (idle_cnt),
        .cfg_char  (cfg_char),
        .cfg_num   (cfg_num),
        .cfg_pre   (cfg_pre_idle),
        .cfg_gap   (cfg_gap),
        .cfg_post  (cfg_post_idle),
        .det_pulse (esc_det),
        .seq_busy  (esc_busy),
        .seq_cnt   (esc_matched)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!esc_det && !esc_busy && esc_matched == '0));
endmodule

// File: tb/at_esc_detect_tb_top.sv
// Bench: directed guard corner cases plus seeded random byte/tick streams,
// compared against a tick-level model of the escape guards.
module at_esc_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        rx_vld = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [7:0]  cfg_char = 8'h2B;
    logic [7:0]  cfg_num = 8'd3;
    logic [15:0] cfg_pre_idle = 16'd4;
    logic [15:0] cfg_gap = 16'd3;
    logic [15:0] cfg_post_idle = 16'd4;
    logic        esc_det;
    logic        esc_busy;
    logic [7:0]  esc_matched;

    int checks = 0;
    int errors = 0;
    int det_seen = 0;
    int ev_gap [16];
    int ev_byte[16];

    always #4 clk = ~clk;

    at_esc_detect dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_vld(rx_vld),
        .rx_data(rx_data), .cfg_char(cfg_char), .cfg_num(cfg_num),
        .cfg_pre_idle(cfg_pre_idle), .cfg_gap(cfg_gap),
        .cfg_post_idle(cfg_post_idle), .esc_det(esc_det),
        .esc_busy(esc_busy), .esc_matched(esc_matched)
    );

    always @(negedge clk) if (rst_n && esc_det) det_seen++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic v, input logic [7:0] d);
        @(negedge clk);
        baud_tick = t; rx_vld = v; rx_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin cyc(1'b1, 1'b0, 8'h00); cyc(1'b0, 1'b0, 8'h00); end
    endtask

    task automatic put(input logic [7:0] b);
        cyc(1'b0, 1'b1, b); cyc(1'b0, 1'b0, 8'h00);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        settle(3);
        rst_n = 1'b1;
        det_seen = 0;
    endtask

    // Tick-level model of the guards: number of detections for a stream.
    function automatic int model_dets(input int n, input int trail);
        int st = 0; int m = 0; int dets = 0; int need;
        need = (cfg_num == 0) ? 1 : int'(cfg_num);
        for (int i = 0; i < n; i++) begin
            if (st == 2 && ev_gap[i] >= int'(cfg_post_idle)) begin dets++; st = 0; m = 0; end
            if (st == 1 && ev_gap[i] > int'(cfg_gap)) begin st = 0; m = 0; end
            if (st == 2) begin st = 0; m = 0; end
            else if (st == 0) begin
                if (ev_byte[i] == int'(cfg_char) && ev_gap[i] >= int'(cfg_pre_idle)) begin
                    m = 1; st = (need <= 1) ? 2 : 1;
                end
            end else begin
                if (ev_byte[i] == int'(cfg_char)) begin m++; if (m >= need) st = 2; end
                else begin st = 0; m = 0; end
            end
        end
        if (st == 2 && trail >= int'(cfg_post_idle)) dets++;
        return dets;
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        do_reset();
        chk("R1 det", int'(esc_det), 0);
        chk("R1 busy", int'(esc_busy), 0);
        chk("R1 matched", int'(esc_matched), 0);

        // R5 R8 R9: normal sequence, exact pre-idle and exact gap
        idle(4); put(8'h2B);
        chk("R8 busy after first", int'(esc_busy), 1);
        idle(3); put(8'h2B); idle(1); put(8'h2B);
        chk("R8 matched full", int'(esc_matched), 3);
        idle(3); settle(3);
        chk("R5 no early det", det_seen, 0);
        idle(1); settle(3);
        chk("R9 single pulse", det_seen, 1);
        chk("R5 busy cleared", int'(esc_busy), 0);
        chk("R5 matched cleared", int'(esc_matched), 0);

        // R2: pre-idle one tick short
        do_reset();
        idle(3); put(8'h2B);
        chk("R2 short pre", int'(esc_busy), 0);

        // R3: mismatch while collecting
        do_reset();
        idle(5); put(8'h2B); put(8'h2B);
        chk("R8 matched two", int'(esc_matched), 2);
        put(8'h41);
        chk("R3 matched", int'(esc_matched), 0);
        chk("R3 busy", int'(esc_busy), 0);

        // R4: gap exceeded
        do_reset();
        idle(5); put(8'h2B); idle(4); settle(2);
        chk("R4 gap timeout", int'(esc_busy), 0);

        // R6: byte during post wait cancels
        do_reset();
        idle(4); put(8'h2B); put(8'h2B); put(8'h2B); idle(2); put(8'h00);
        idle(10); settle(3);
        chk("R6 cancelled", det_seen, 0);

        // R7: count of zero and one
        do_reset();
        cfg_num = 8'd0;
        idle(4); put(8'h2B); idle(4); settle(3);
        chk("R7 count zero", det_seen, 1);
        do_reset();
        cfg_num = 8'd1; cfg_post_idle = 16'd0;
        idle(4); put(8'h2B); settle(3);
        chk("R7 count one, post zero", det_seen, 1);

        // R2 R3 R4 R5 R6 R7: seeded random streams against the model
        for (int s = 0; s < 60; s++) begin
            int n; int trail; int exp_d;
            cfg_char      = 8'($urandom_range(0, 255));
            cfg_num       = 8'($urandom_range(0, 4));
            cfg_pre_idle  = 16'($urandom_range(0, 6));
            cfg_gap       = 16'($urandom_range(1, 5));
            cfg_post_idle = 16'($urandom_range(0, 6));
            n     = $urandom_range(1, 16);
            trail = $urandom_range(0, 8);
            for (int i = 0; i < n; i++) begin
                ev_gap[i]  = $urandom_range(0, 8);
                ev_byte[i] = ($urandom_range(0, 3) != 0) ? int'(cfg_char) : $urandom_range(0, 255);
            end
            do_reset();
            for (int i = 0; i < n; i++) begin idle(ev_gap[i]); put(8'(ev_byte[i])); end
            idle(trail); settle(3);
            exp_d = model_dets(n, trail);
            chk("R5 random stream detections", det_seen, exp_d);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule